// File: doc/BRIEF.md
# Delayed Integration Gate Sequencer

This block sequences one integrating sub-channel of a pulse-shape front end. It uses cycle counters for all of its timing. While idle it keeps the integrator discharged. A start strobe begins a programmable delay. When the delay ends, the block releases the discharge and closes the integration switch for a programmable width. It then opens the switch and holds the integrated value. The hold ends when the readout logic reports that the sample was taken, or when an automatic-reset timeout expires. Either way the block returns to the discharged idle state.

Each of the delay and the width is set by an unsigned code and a 2-bit range select. Each range has its own minimum and maximum time, and the code spans that interval linearly. The result is converted to a count of clock cycles. The delay and the width have separate range selects. At chip level, every sub-channel of the same letter drives these range inputs from one shared setting. The timeout is a separate code, counted from the first busy cycle after the start. The block samples the delay, width and timeout settings when a start is accepted. It ignores any start that arrives while a sequence is running.

Top module: `gate_seq_top`

## Requirements
- R1: Out of reset and whenever idle, `dump_o` is 1 and `int_o` and `hold_o` are 0. In every cycle exactly one of the phase outputs is high: `dump_o` (idle or delay), `int_o` (integration) or `hold_o` (hold).
- R2: A time code converts to cycles as follows. First ns = lo + (hi - lo) * code / (2^CODE_W - 1), using integer division. The cycle count is then ns / CLK_NS, with a minimum of 1. The range select sets the interval: 0 = 10..50 ns, 1 = 30..150 ns, 2 = 120..600 ns, 3 = 2000..10000 ns.
- R3: Suppose a start is accepted at a clock edge. `dump_o` then stays 1 for exactly D further cycles, where D is the delay cycle count. In the next cycle `dump_o` falls and `int_o` rises together.
- R4: `int_o` stays 1 for exactly W cycles, where W is the width cycle count. It then falls as `hold_o` rises.
- R5: If `rd_done_i` is sampled high during hold, the next cycle shows `hold_o` = 0 and `dump_o` = 1.
- R6: T = (timeout code + 1) * TMO_STEP cycles. If no readout has ended the sequence, the block returns to idle after T busy cycles, whatever phase it is in.
- R7: The delay range select affects only the delay, and the width range select affects only the width.
- R8: A start strobe seen while busy has no effect. `rd_done_i` has no effect outside the hold phase.
- R9: Delay, width and timeout settings are captured when a start is accepted. Changing them during a sequence does not change that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Event start strobe |
| dly_code_i | input | CODE_W | Delay position within its range |
| dly_rng_i | input | 2 | Delay range select |
| wid_code_i | input | CODE_W | Width position within its range |
| wid_rng_i | input | 2 | Width range select |
| tmo_code_i | input | TMO_W | Automatic-reset timeout code |
| rd_done_i | input | 1 | Held value has been sampled |
| dump_o | output | 1 | Integrator discharge active |
| int_o | output | 1 | Integration switch closed |
| hold_o | output | 1 | Result held and valid |

## Verification
The assertions check the phase ordering on every cycle. They confirm that exactly one phase output is high, and that integration opens only from discharge. They also confirm that integration closes into hold or discharge, and that a hold lasts until a readout or a discharge. Exact phase lengths can only be shown by the bench scenarios, which count cycles against values computed from the range table and codes. The same applies to timeout expiry in the delay and hold phases, to ignored strobes, and to settings captured at start.

// File: rtl/gate_seq_pkg.sv
`timescale 1ns/1ps
package gate_seq_pkg;

    typedef logic [1:0] rng_sel_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_OPEN = 2'd2,
        SEQ_HELD = 2'd3
    } seq_state_e;

    // Lower bound of a time range, in ns
    function automatic int unsigned range_lo_ns(input rng_sel_t sel);
        case (sel)
            2'd0:    return 10;
            2'd1:    return 30;
            2'd2:    return 120;
            default: return 2000;
        endcase
    endfunction

    // Upper bound of a time range, in ns
    function automatic int unsigned range_hi_ns(input rng_sel_t sel);
        case (sel)
            2'd0:    return 50;
            2'd1:    return 150;
            2'd2:    return 600;
            default: return 10000;
        endcase
    endfunction

    // Linear interpolation of a code inside the selected range
    function automatic int unsigned window_ns(input rng_sel_t sel,
                                              input int unsigned code,
                                              input int unsigned code_max);
        int unsigned lo;
        int unsigned hi;
        lo = range_lo_ns(sel);
        hi = range_hi_ns(sel);
        return lo + ((hi - lo) * code) / code_max;
    endfunction

endpackage

// File: rtl/gate_seq_timecalc.sv
`timescale 1ns/1ps
module gate_seq_timecalc
    import gate_seq_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CLK_NS = 5,
    parameter int TIME_W = 16
) (
    input  rng_sel_t            rng,
    input  logic [CODE_W-1:0]   code,
    output logic [TIME_W-1:0]   cycles
);
    localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

    always_comb begin
        int unsigned ns;
        int unsigned cyc;
        ns  = window_ns(rng, 32'(code), CODE_MAX);
        cyc = ns / CLK_NS;
        if (cyc == 0) cyc = 1;
        cycles = TIME_W'(cyc);
    end
endmodule

// File: rtl/gate_seq_timer.sv
`timescale 1ns/1ps
module gate_seq_timer #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TIME_W-1:0] load_val,
    output logic              zero
);
    logic [TIME_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/gate_seq_fsm.sv
`timescale 1ns/1ps
module gate_seq_fsm
    import gate_seq_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_done,
    input  logic              ph_zero,
    input  logic              age_zero,
    input  logic [TIME_W-1:0] d_cyc,
    input  logic [TIME_W-1:0] w_cyc,
    input  logic [TIME_W-1:0] t_cyc,
    output logic              ph_load,
    output logic [TIME_W-1:0] ph_val,
    output logic              age_load,
    output logic [TIME_W-1:0] age_val,
    output seq_state_e        state
);
    seq_state_e st_q, st_d;

    always_comb begin
        st_d     = st_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        age_load = 1'b0;
        age_val  = '0;
        case (st_q)
            SEQ_IDLE: if (start) begin
                st_d     = SEQ_WAIT;
                ph_load  = 1'b1;
                ph_val   = d_cyc - 1'b1;
                age_load = 1'b1;
                age_val  = t_cyc - 1'b1;
            end
            SEQ_WAIT: if (age_zero) begin
                st_d     = SEQ_IDLE;
                ph_load  = 1'b1;
                age_load = 1'b1;
            end else if (ph_zero) begin
                st_d     = SEQ_OPEN;
                ph_load  = 1'b1;
                ph_val   = w_cyc - 1'b1;
            end
            SEQ_OPEN: if (age_zero) begin
                st_d     = SEQ_IDLE;
                ph_load  = 1'b1;
                age_load = 1'b1;
            end else if (ph_zero) begin
                st_d     = SEQ_HELD;
            end
            default: if (rd_done || age_zero) begin
                st_d     = SEQ_IDLE;
                ph_load  = 1'b1;
                age_load = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SEQ_IDLE;
        else     st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/gate_seq_top.sv
`timescale 1ns/1ps
module gate_seq_top
    import gate_seq_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int TMO_W    = 6,
    parameter int CLK_NS   = 5,
    parameter int TMO_STEP = 20,
    parameter int TIME_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CODE_W-1:0] dly_code_i,
    input  logic [1:0]        dly_rng_i,
    input  logic [CODE_W-1:0] wid_code_i,
    input  logic [1:0]        wid_rng_i,
    input  logic [TMO_W-1:0]  tmo_code_i,
    input  logic              rd_done_i,
    output logic              dump_o,
    output logic              int_o,
    output logic              hold_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        rng_sel_t          rng;
    } win_cfg_t;

    localparam int NTIMERS = 2;  // 0: phase (delay/width), 1: event age

    seq_state_e        state;
    win_cfg_t          wid_q;
    logic [TIME_W-1:0] d_cyc, w_cyc, t_cyc;
    logic [TIME_W-1:0] ld_val [NTIMERS];
    logic              ld     [NTIMERS];
    logic              zr     [NTIMERS];
    logic              accept;

    assign accept = (state == SEQ_IDLE) && start_i;

    // Width settings are captured at start (R9); delay and timeout are
    // consumed in the same edge that accepts the start.
    always_ff @(posedge clk) begin
        if (rst)         wid_q <= '0;
        else if (accept) wid_q <= '{code: wid_code_i, rng: wid_rng_i};
    end

    gate_seq_timecalc #(.CODE_W(CODE_W), .CLK_NS(CLK_NS), .TIME_W(TIME_W)) u_dly_calc (
        .rng(dly_rng_i), .code(dly_code_i), .cycles(d_cyc));

    gate_seq_timecalc #(.CODE_W(CODE_W), .CLK_NS(CLK_NS), .TIME_W(TIME_W)) u_wid_calc (
        .rng(wid_q.rng), .code(wid_q.code), .cycles(w_cyc));

    assign t_cyc = TIME_W'((32'(tmo_code_i) + 32'd1) * 32'(TMO_STEP));

    gate_seq_fsm #(.TIME_W(TIME_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .rd_done  (rd_done_i),
        .ph_zero  (zr[0]),
        .age_zero (zr[1]),
        .d_cyc    (d_cyc),
        .w_cyc    (w_cyc),
        .t_cyc    (t_cyc),
        .ph_load  (ld[0]),
        .ph_val   (ld_val[0]),
        .age_load (ld[1]),
        .age_val  (ld_val[1]),
        .state    (state)
    );

    for (genvar g = 0; g < NTIMERS; g++) begin : g_tmr
        gate_seq_timer #(.TIME_W(TIME_W)) u_tmr (
            .clk(clk), .rst(rst), .load(ld[g]), .load_val(ld_val[g]), .zero(zr[g]));
    end

    assign dump_o = (state == SEQ_IDLE) || (state == SEQ_WAIT);
    assign int_o  = (state == SEQ_OPEN);
    assign hold_o = (state == SEQ_HELD);
endmodule

// File: rtl/gate_seq_checker.sv
`timescale 1ns/1ps
module gate_seq_checker (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic rd_done_i,
    input logic dump_o,
    input logic int_o,
    input logic hold_o
);
    assert_one_phase_R1: assert property (@(posedge clk) disable iff (rst)
        $countones({dump_o, int_o, hold_o}) == 1);

    assert_open_from_dump_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(int_o) |-> $past(dump_o));

    assert_close_to_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(int_o) |-> (hold_o || dump_o));

    assert_hold_from_int_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_o) |-> $past(int_o));

    assert_readout_releases_R5: assert property (@(posedge clk) disable iff (rst)
        (hold_o && rd_done_i) |=> (dump_o && !hold_o));

    assert_hold_persists_R6: assert property (@(posedge clk) disable iff (rst)
        hold_o |=> (hold_o || dump_o));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (hold_o && start_i && !rd_done_i) |=> !int_o);
endmodule

bind gate_seq_top gate_seq_checker u_gate_seq_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .rd_done_i(rd_done_i),
    .dump_o(dump_o), .int_o(int_o), .hold_o(hold_o));

// File: tb/gate_seq_top_bench.sv
`timescale 1ns/1ps
module gate_seq_top_bench;
    localparam int CW = 4;
    localparam int TW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [CW-1:0] dly_code_i = '0;
    logic [1:0] dly_rng_i = '0;
    logic [CW-1:0] wid_code_i = '0;
    logic [1:0] wid_rng_i = '0;
    logic [TW-1:0] tmo_code_i = '0;
    logic rd_done_i = 1'b0;
    logic dump_o, int_o, hold_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gate_seq_top u_gate_seq_top (
        .clk(clk), .rst(rst), .start_i(start_i),
        .dly_code_i(dly_code_i), .dly_rng_i(dly_rng_i),
        .wid_code_i(wid_code_i), .wid_rng_i(wid_rng_i),
        .tmo_code_i(tmo_code_i), .rd_done_i(rd_done_i),
        .dump_o(dump_o), .int_o(int_o), .hold_o(hold_o));

    // R2 conversion, derived from the requirement text
    function automatic int exp_cyc(input int rng, input int code);
        int lo, hi, ns, c;
        case (rng)
            0: begin lo = 10;   hi = 50;    end
            1: begin lo = 30;   hi = 150;   end
            2: begin lo = 120;  hi = 600;   end
            default: begin lo = 2000; hi = 10000; end
        endcase
        ns = lo + ((hi - lo) * code) / 15;
        c = ns / 5;
        if (c < 1) c = 1;
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch(input int dr, input int dc, input int wr, input int wc, input int tc);
        @(negedge clk);
        dly_rng_i = 2'(dr); dly_code_i = CW'(dc);
        wid_rng_i = 2'(wr); wid_code_i = CW'(wc);
        tmo_code_i = TW'(tc);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Count delay and width cycles; optional side stimulus
    task automatic measure(output int d, output int w,
                           input bit rd_in_dly, input bit start_in_int, input bit swap_cfg);
        d = 0;
        while (!int_o && d < 5000) begin
            d++;
            if (d == 1 && rd_in_dly) rd_done_i = 1'b1;
            if (d == 1 && swap_cfg) begin
                wid_rng_i = 2'd3; wid_code_i = 4'd15;
                dly_rng_i = 2'd3; tmo_code_i = '0;
            end
            @(negedge clk);
            rd_done_i = 1'b0;
        end
        w = 0;
        while (int_o && w < 5000) begin
            w++;
            if (w == 1 && start_in_int) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    task automatic readout(input string req);
        rd_done_i = 1'b1;
        @(negedge clk);
        rd_done_i = 1'b0;
        chk(dump_o && !hold_o && !int_o, req, {dump_o, int_o, hold_o}, 3'b100);
    endtask

    task automatic t_reset;
        chk(dump_o == 1'b1, "R1 dump after reset", dump_o, 1);
        chk(!int_o && !hold_o, "R1 int/hold after reset", {int_o, hold_o}, 0);
    endtask

    task automatic t_basic;
        int d, w;
        launch(0, 0, 0, 0, 63);
        measure(d, w, 0, 0, 0);
        chk(d == exp_cyc(0, 0), "R3 delay r0 c0", d, exp_cyc(0, 0));
        chk(w == exp_cyc(0, 0), "R4 width r0 c0", w, exp_cyc(0, 0));
        chk(hold_o && !dump_o, "R4 hold after width", hold_o, 1);
        repeat (5) @(negedge clk);
        chk(hold_o == 1'b1, "R6 hold persists", hold_o, 1);
        readout("R5 readout releases");
    endtask

    task automatic t_ranges;
        int d, w;
        launch(1, 15, 0, 7, 63);
        measure(d, w, 0, 0, 0);
        chk(d == exp_cyc(1, 15), "R7 delay r1 c15", d, exp_cyc(1, 15));
        chk(w == exp_cyc(0, 7), "R2 width r0 c7", w, exp_cyc(0, 7));
        readout("R5 readout");
        launch(2, 5, 3, 0, 63);
        measure(d, w, 0, 0, 0);
        chk(d == exp_cyc(2, 5), "R2 delay r2 c5", d, exp_cyc(2, 5));
        chk(w == exp_cyc(3, 0), "R7 width r3 c0", w, exp_cyc(3, 0));
        readout("R5 readout");
    endtask

    task automatic t_timeout_hold;
        int d, w, h;
        launch(0, 0, 0, 15, 2);
        measure(d, w, 0, 0, 0);
        h = 0;
        while (hold_o && h < 5000) begin h++; @(negedge clk); end
        chk(h == 60 - d - w, "R6 hold timeout length", h, 60 - d - w);
        chk(dump_o == 1'b1, "R6 dump after timeout", dump_o, 1);
    endtask

    task automatic t_timeout_delay;
        int d, w;
        bit opened;
        opened = 1'b0;
        launch(3, 15, 0, 0, 0);
        for (int i = 0; i < 40; i++) begin
            if (int_o) opened = 1'b1;
            @(negedge clk);
        end
        chk(!opened, "R6 no window after delay timeout", opened, 0);
        launch(0, 3, 0, 3, 63);
        measure(d, w, 0, 0, 0);
        chk(d == exp_cyc(0, 3), "R6 idle again after timeout", d, exp_cyc(0, 3));
        readout("R5 readout");
    endtask

    task automatic t_ignore;
        int d, w;
        launch(0, 15, 1, 0, 63);
        measure(d, w, 1, 1, 0);
        chk(d == exp_cyc(0, 15), "R8 rd_done in delay ignored", d, exp_cyc(0, 15));
        chk(w == exp_cyc(1, 0), "R8 start in window ignored", w, exp_cyc(1, 0));
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk(hold_o && !int_o, "R8 start in hold ignored", hold_o, 1);
        readout("R5 readout");
    endtask

    task automatic t_latch;
        int d, w, h;
        launch(1, 0, 2, 0, 63);
        measure(d, w, 0, 0, 1);
        chk(d == exp_cyc(1, 0), "R9 delay kept", d, exp_cyc(1, 0));
        chk(w == exp_cyc(2, 0), "R9 width kept", w, exp_cyc(2, 0));
        h = 0;
        while (hold_o && h < 100) begin h++; @(negedge clk); end
        chk(h == 100, "R9 timeout kept", h, 100);
        readout("R5 readout");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ranges();
        t_timeout_hold();
        t_timeout_delay();
        t_ignore();
        t_latch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule